// File: doc/BRIEF.md
# Sub-pixel bilinear predictor interpolator

This block turns a stream of reference rows into a block of predicted 8-bit pixels. Each pixel is formed by two-tap bilinear interpolation at an eighth-pel position, set separately in x and y. A start pulse loads the two offset indices, a compound enable and a height code. The block then takes one reference row per accepted beat. Each row is 32 pixels wide, plus one extra pixel on the right that feeds the horizontal neighbour. Every row is filtered horizontally first. The block keeps the previous filtered row, and the vertical pass combines it with the current one.

The first row of a block only primes that stored row. Each later row gives one output row. A block of height H therefore uses H+1 reference rows. In compound mode, every interpolated pixel is also averaged, with rounding, with a co-located pixel from a second predictor row. That second row arrives on the same beat as the reference row. Output rows are handed to a downstream distortion accumulator over a valid/ready handshake, and the final row of the block is flagged.

Top module: `subpel_interp`

## Requirements
- R1: For horizontal index k (0..7), pixel c of a filtered row is ((16-2k)*p[c] + 2k*p[c+1] + 8) >> 4. Here p[c+1] is the right-hand neighbour, and column 31 uses the extra pixel 32 of the input row.
- R2: For vertical index k, output row i is ((16-2k)*A + 2k*B + 8) >> 4 for each pixel. A is the horizontally filtered reference row i and B is the horizontally filtered reference row i+1, counted from the start of the block.
- R3: Index 0 on an axis passes that axis through unchanged. Index 4 gives the rounded average (a+b+1)>>1.
- R4: The horizontal result is rounded and limited to 8 bits before the vertical pass uses it. Results stay exact with all-255 and alternating 0/255 data.
- R5: The first row accepted after a start produces no output beat. Exactly H+1 rows are accepted per block. in_ready stays low outside a block.
- R6: With compound enabled, each output pixel is (p+s+1)>>1. s is pixel c of in_sec, taken on the same beat as the reference row that completes that output row. in_sec is ignored on the priming beat.
- R7: height_code 0, 1 and 2 select 16, 32 and 64 rows, and code 3 also selects 64. Exactly H output beats are sent, and out_last is high on the last one only.
- R8: While out_valid is high and out_ready is low, out_pix and out_last hold and no further reference row is accepted.
- R9: A start pulse during a block is ignored. Offsets, compound enable and height are taken only at an accepted start.
- R10: After reset, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block (taken only when idle) |
| x_idx | input | 3 | Horizontal eighth-pel index |
| y_idx | input | 3 | Vertical eighth-pel index |
| cmp_en | input | 1 | Compound averaging enable |
| height_code | input | 2 | Block height select |
| in_valid | input | 1 | Reference row valid |
| in_ready | output | 1 | Reference row accepted when high with in_valid |
| in_ref | input | 264 | 33 reference pixels, pixel j at bits 8j+7:8j |
| in_sec | input | 256 | 32 second-predictor pixels, same packing |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Downstream accepts the row |
| out_pix | output | 256 | 32 predicted pixels, pixel j at bits 8j+7:8j |
| out_last | output | 1 | Final row of the block |

## Verification
The hardest state to reach is an accepted reference row that meets a full output register. At that moment the handshake must stall the input, so that the stored vertical row is not overwritten. The stimulus reaches it by randomly dropping out_ready and in_valid during 32- and 64-row blocks. It then confirms that every row still matches a model computed in the bench, and that stalled outputs do not move. A start pulse is also injected partway through a block, with the offset inputs changed, to show that the block ignores it.

// File: rtl/subpel_pkg.sv
// Shared types and pixel arithmetic for the sub-pixel interpolator.
// Assumes 8-bit unsigned pixels and eighth-pel indices of 3 bits.
package subpel_pkg;
    localparam int PIX_W = 8;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {PH_IDLE, PH_PRIME, PH_RUN} phase_t;

    // Two-tap filter with taps (16-2k, 2k), round by 8, shift by 4, clamp to 8 bits.
    function automatic logic [PIX_W-1:0] tap2(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b,
                                              input logic [IDX_W-1:0] k);
        logic [4:0]  w_near;
        logic [4:0]  w_far;
        logic [13:0] acc;
        logic [9:0]  sh;
        w_far  = {1'b0, k, 1'b0};
        w_near = 5'd16 - w_far;
        acc    = 14'(w_near) * 14'(a) + 14'(w_far) * 14'(b) + 14'd8;
        sh     = acc[13:4];
        tap2   = (sh > 10'd255) ? 8'hFF : sh[PIX_W-1:0];
    endfunction

    // Rounded mean of two pixels.
    function automatic logic [PIX_W-1:0] avg2(input logic [PIX_W-1:0] a,
                                              input logic [PIX_W-1:0] b);
        logic [PIX_W:0] s;
        s    = {1'b0, a} + {1'b0, b} + 9'd1;
        avg2 = s[PIX_W:1];
    endfunction
endpackage

// File: rtl/subpel_hfilt.sv
// Horizontal pass: filters one reference row of NPIX+1 pixels into NPIX pixels.
// Assumes pixel j of the input lies at bits PIX_W*j+PIX_W-1 : PIX_W*j.
module subpel_hfilt
    import subpel_pkg::*;
#(
    parameter int NPIX = 32
) (
    input  logic [(NPIX+1)*PIX_W-1:0] row_in,
    input  logic [IDX_W-1:0]          k,
    output logic [NPIX*PIX_W-1:0]     row_out
);
    for (genvar c = 0; c < NPIX; c++) begin : g_col
        // Filter pixel c against its right-hand neighbour.
        always_comb begin
            row_out[c*PIX_W +: PIX_W] = tap2(row_in[c*PIX_W +: PIX_W],
                                             row_in[(c+1)*PIX_W +: PIX_W], k);
        end
    end
endmodule

// File: rtl/subpel_vfilt.sv
// Vertical pass plus optional compound averaging for one row of NPIX pixels.
// Assumes upper and lower rows are already horizontally filtered.
module subpel_vfilt
    import subpel_pkg::*;
#(
    parameter int NPIX = 32
) (
    input  logic [NPIX*PIX_W-1:0] upper,
    input  logic [NPIX*PIX_W-1:0] lower,
    input  logic [NPIX*PIX_W-1:0] second,
    input  logic [IDX_W-1:0]      k,
    input  logic                  cmp,
    output logic [NPIX*PIX_W-1:0] row_out
);
    for (genvar c = 0; c < NPIX; c++) begin : g_col
        logic [PIX_W-1:0] v;
        // Blend rows, then optionally average with the second predictor.
        always_comb begin
            v = tap2(upper[c*PIX_W +: PIX_W], lower[c*PIX_W +: PIX_W], k);
            row_out[c*PIX_W +: PIX_W] = cmp ? avg2(v, second[c*PIX_W +: PIX_W]) : v;
        end
    end
endmodule

// File: rtl/subpel_ctrl.sv
// Sequencer: latches block settings on start, takes one priming row, then
// height rows, each allowed only when the output register can take a result.
module subpel_ctrl
    import subpel_pkg::*;
#(
    parameter int BASE_H = 16,
    parameter int HW     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] x_idx,
    input  logic [IDX_W-1:0] y_idx,
    input  logic             cmp_en,
    input  logic [1:0]       height_code,
    input  logic             in_valid,
    input  logic             out_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             prime_fire,
    output logic             run_fire,
    output logic             last_row,
    output logic             busy,
    output logic [IDX_W-1:0] kx,
    output logic [IDX_W-1:0] ky,
    output logic             cmp_l,
    output logic [HW-1:0]    blk_height
);
    phase_t        phase;
    logic [HW-1:0] row_cnt;
    logic [HW-1:0] h_dec;

    // Decode the height code; code 3 falls back to the largest height.
    always_comb begin
        case (height_code)
            2'd0:    h_dec = HW'(BASE_H);
            2'd1:    h_dec = HW'(BASE_H * 2);
            default: h_dec = HW'(BASE_H * 4);
        endcase
    end

    // Handshake and phase-derived strobes.
    always_comb begin
        in_ready   = (phase == PH_PRIME) ||
                     ((phase == PH_RUN) && (!out_valid || out_ready));
        prime_fire = in_valid && in_ready && (phase == PH_PRIME);
        run_fire   = in_valid && in_ready && (phase == PH_RUN);
        last_row   = (row_cnt == blk_height - HW'(1));
        busy       = (phase != PH_IDLE);
    end

    // Phase machine, settings latch and output-row counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            row_cnt    <= '0;
            kx         <= '0;
            ky         <= '0;
            cmp_l      <= 1'b0;
            blk_height <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    kx         <= x_idx;
                    ky         <= y_idx;
                    cmp_l      <= cmp_en;
                    blk_height <= h_dec;
                    row_cnt    <= '0;
                    phase      <= PH_PRIME;
                end
                PH_PRIME: if (prime_fire) phase <= PH_RUN;
                PH_RUN: if (run_fire) begin
                    row_cnt <= row_cnt + HW'(1);
                    if (last_row) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/subpel_interp.sv
// Top: separable bilinear interpolator streaming ROW_PIX-wide predicted rows.
// Assumes each reference row carries one extra pixel on the right and that
// the second-predictor row arrives on the same beat as its reference row.
module subpel_interp
    import subpel_pkg::*;
#(
    parameter int ROW_PIX = 32,
    parameter int BASE_H  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 x_idx,
    input  logic [2:0]                 y_idx,
    input  logic                       cmp_en,
    input  logic [1:0]                 height_code,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [(ROW_PIX+1)*8-1:0]   in_ref,
    input  logic [ROW_PIX*8-1:0]       in_sec,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [ROW_PIX*8-1:0]       out_pix,
    output logic                       out_last
);
    localparam int MAX_H = BASE_H * 4;
    localparam int HW    = $clog2(MAX_H + 1);
    localparam int ROW_W = ROW_PIX * PIX_W;

    logic             prime_fire, run_fire, last_row, ctl_busy, cmp_l;
    logic [IDX_W-1:0] kx, ky;
    logic [HW-1:0]    blk_height;
    logic [ROW_W-1:0] hrow, vrow, prev_row;

    subpel_ctrl #(.BASE_H(BASE_H), .HW(HW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_idx(x_idx), .y_idx(y_idx), .cmp_en(cmp_en), .height_code(height_code),
        .in_valid(in_valid), .out_valid(out_valid), .out_ready(out_ready),
        .in_ready(in_ready), .prime_fire(prime_fire), .run_fire(run_fire),
        .last_row(last_row), .busy(ctl_busy), .kx(kx), .ky(ky), .cmp_l(cmp_l),
        .blk_height(blk_height)
    );

    subpel_hfilt #(.NPIX(ROW_PIX)) u_hf (
        .row_in(in_ref), .k(kx), .row_out(hrow)
    );

    subpel_vfilt #(.NPIX(ROW_PIX)) u_vf (
        .upper(prev_row), .lower(hrow), .second(in_sec),
        .k(ky), .cmp(cmp_l), .row_out(vrow)
    );

    // Keep the latest horizontally filtered row for the next vertical blend.
    always_ff @(posedge clk) begin
        if (!rst_n)                     prev_row <= '0;
        else if (prime_fire || run_fire) prev_row <= hrow;
    end

    // Output register: load on each non-priming row, drop after hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_last  <= 1'b0;
        end else if (run_fire) begin
            out_valid <= 1'b1;
            out_pix   <= vrow;
            out_last  <= last_row;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/subpel_interp_chk.sv
// Checker bound to the interpolator top; observes handshakes and block framing.
module subpel_interp_chk #(
    parameter int ROW_W = 256,
    parameter int HW    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [ROW_W-1:0] out_pix,
    input logic             ctl_busy,
    input logic [HW-1:0]    blk_height
);
    logic          rst_q;
    logic [HW-1:0] in_cnt, out_cnt, chk_h;

    // Count rows accepted within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_busy)         in_cnt <= '0;
        else if (in_valid && in_ready)   in_cnt <= in_cnt + HW'(1);
    end

    // Count output beats per block and capture the block height at the first beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt <= '0;
            chk_h   <= '0;
        end else if (out_valid && out_ready) begin
            if (out_cnt == '0) chk_h <= blk_height;
            out_cnt <= out_last ? '0 : out_cnt + HW'(1);
        end
    end

    // Outputs must be quiet on the first cycle after reset is released.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        if (rst_n && !rst_q) begin
            p_reset_quiet_r10: assert (!out_valid && !in_ready)
                else $error("output active right after reset");
        end
    end

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_last));

    p_idle_noready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_busy |-> !in_ready);

    p_row_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> ctl_busy && (in_cnt <= blk_height));

    p_last_position_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |-> (out_cnt == chk_h - HW'(1)));
endmodule

bind subpel_interp subpel_interp_chk #(.ROW_W(ROW_W), .HW(HW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_pix(out_pix), .ctl_busy(ctl_busy), .blk_height(blk_height)
);

// File: tb/tb_subpel_interp.sv
`timescale 1ns/1ps
module tb_subpel_interp;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   x_idx = '0, y_idx = '0;
    logic         cmp_en = 1'b0;
    logic [1:0]   height_code = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [263:0] in_ref = '0;
    logic [255:0] in_sec = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [255:0] out_pix;
    logic         out_last;

    int errors = 0;
    int checks = 0;

    logic [7:0]   refm [0:64][0:32];
    logic [7:0]   secm [0:63][0:31];
    logic [255:0] expq [0:63];

    always #2 clk = ~clk;

    subpel_interp dut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_idx(x_idx), .y_idx(y_idx),
        .cmp_en(cmp_en), .height_code(height_code), .in_valid(in_valid),
        .in_ready(in_ready), .in_ref(in_ref), .in_sec(in_sec),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_last(out_last)
    );

    // Watchdog: a hung run is one failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int tapm(input int a, input int b, input int k);
        int v;
        v = ((16 - 2*k) * a + 2*k * b + 8) / 16;
        return (v > 255) ? 255 : v;
    endfunction

    // mode 0: random, 1: all 255, 2: alternating 0/255
    task automatic fill(input int mode);
        for (int r = 0; r <= 64; r++)
            for (int c = 0; c <= 32; c++)
                refm[r][c] = (mode == 0) ? 8'($urandom) :
                             (mode == 1) ? 8'hFF : (((r + c) % 2) ? 8'hFF : 8'h00);
        for (int r = 0; r < 64; r++)
            for (int c = 0; c < 32; c++)
                secm[r][c] = (mode == 1) ? 8'hFF : 8'($urandom);
    endtask

    task automatic model(input int kx, input int ky, input bit cmp, input int h);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < 32; c++) begin
                int a, b, v;
                a = tapm(refm[r][c], refm[r][c+1], kx);
                b = tapm(refm[r+1][c], refm[r+1][c+1], kx);
                v = tapm(a, b, ky);
                if (cmp) v = (v + secm[r][c] + 1) / 2;
                expq[r][c*8 +: 8] = 8'(v);
            end
    endtask

    task automatic run_block(input int kx, input int ky, input bit cmp, input int hc,
                             input bit stall, input bit midstart, input string req);
        int h, ri, oi;
        bit held, prime_look, mid_done;
        logic [255:0] held_pix;
        h = (hc == 0) ? 16 : (hc == 1) ? 32 : 64;
        model(kx, ky, cmp, h);
        @(negedge clk);
        start = 1'b1; x_idx = 3'(kx); y_idx = 3'(ky); cmp_en = cmp; height_code = 2'(hc);
        @(negedge clk);
        start = 1'b0; x_idx = ~x_idx; y_idx = ~y_idx; cmp_en = ~cmp; height_code = 2'd0;
        ri = 0; oi = 0; held = 0; prime_look = 0; mid_done = 0;
        while (oi < h) begin
            @(negedge clk);
            start = 1'b0;
            if (midstart && ri == 5 && !mid_done) begin
                start = 1'b1; x_idx = 3'(kx + 3); y_idx = 3'(ky + 5); mid_done = 1;
            end
            in_valid = (ri <= h) && (!stall || ($urandom % 4 != 0));
            for (int c = 0; c <= 32; c++) in_ref[c*8 +: 8] = refm[(ri <= 64) ? ri : 64][c];
            for (int c = 0; c < 32; c++)
                in_sec[c*8 +: 8] = (ri >= 1) ? secm[ri-1][c] : 8'($urandom);
            out_ready = !stall || ($urandom % 3 != 0);
            #1;
            if (prime_look) begin
                // R5: the priming row must not create an output beat
                chk(!out_valid, "R5", {255'd0, out_valid}, 256'd0);
                prime_look = 0;
            end
            if (held) begin
                // R8: a stalled row must stay in place
                chk(out_valid && out_pix == held_pix, "R8", out_pix, held_pix);
            end
            held = out_valid && !out_ready;
            held_pix = out_pix;
            if (out_valid && out_ready) begin
                chk(out_pix === expq[oi], req, out_pix, expq[oi]);
                // R7: last flag only on the final row
                chk(out_last === (oi == h - 1), "R7", {255'd0, out_last},
                    {255'd0, (oi == h - 1)});
                oi++;
            end
            if (in_valid && in_ready) begin
                ri++;
                if (ri == 1) prime_look = 1;
            end
        end
        @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1;
        #1;
        // R5: exactly h+1 rows taken, nothing more accepted after the block
        chk(ri == h + 1 && !in_ready, "R5", 256'(ri), 256'(h + 1));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: quiet outputs after reset
        chk(!out_valid && !in_ready, "R10", {254'd0, out_valid, in_ready}, 256'd0);
    endtask

    task automatic t_sweep();
        for (int kx = 0; kx < 8; kx++)
            for (int ky = 0; ky < 8; ky++)
                for (int c = 0; c < 2; c++) begin
                    string req;
                    if (c == 1) req = "R6";
                    else if (ky == 0 && kx % 4 != 0) req = "R1";
                    else if (kx % 4 == 0 && ky % 4 == 0) req = "R3";
                    else req = "R2";
                    fill(0);
                    run_block(kx, ky, c[0], 0, 0, 0, req);
                end
    endtask

    task automatic t_extremes();
        fill(1); run_block(3, 5, 1'b1, 0, 0, 0, "R4");
        fill(2); run_block(7, 7, 1'b0, 0, 0, 0, "R4");
        fill(2); run_block(1, 6, 1'b0, 0, 0, 0, "R4");
    endtask

    task automatic t_heights();
        fill(0); run_block(5, 2, 1'b0, 1, 1, 0, "R7");
        fill(0); run_block(2, 7, 1'b1, 2, 1, 0, "R7");
        fill(0); run_block(6, 3, 1'b0, 3, 1, 0, "R7");
    endtask

    task automatic t_busy_start();
        fill(0); run_block(3, 6, 1'b0, 0, 0, 1, "R9");
        fill(0); run_block(4, 1, 1'b1, 1, 1, 1, "R9");
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_extremes();
        t_heights();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule